// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits after a serial receiver's character output and in front of the receive data register. On a multidrop link a transmitter marks some characters as addresses by setting their most significant bit. When filtering is on, the block compares every address-marked character against a small set of programmable station addresses. It then either admits or suppresses the plain data characters that follow, until the next address-marked character arrives.

The admit/suppress verdict is held in a one-bit state register. Address characters themselves never reach the output while filtering is on. With every slot disabled, the block is transparent and forwards every character unchanged. A small register port lets software reach the station addresses and the per-slot enables at any time, including in the middle of reception.

Characters are `CHAR_W` bits wide. The top bit is the address mark and the lower `CHAR_W-1` bits hold the value that is compared. The number of address slots and the choice between a registered and a combinational output are parameters.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, each station-address slot reads 0 and the enable register reads 0. Register select values are: slot k at select k, the enable register at select NUM_SLOTS (bit k enables slot k), and 0 from any other select.
- R2: While no slot is enabled, every received character, including one with its top bit set, appears on the output unchanged.
- R3: While at least one slot is enabled, a character with its top bit set is never forwarded.
- R4: While at least one slot is enabled, an address character whose lower CHAR_W-1 bits equal an enabled slot's value causes the data characters after it (top bit clear) to be forwarded unchanged, up to the next address character.
- R5: An address character that equals no enabled slot causes the data characters after it to be dropped.
- R6: After reset, with filtering on, data characters received before any matching address character are dropped.
- R7: A slot whose enable bit is clear takes no part in matching, even when its value equals the address character.
- R8: A register write in the same cycle as an address character does not affect that comparison, which uses the old register values. A write also never changes the verdict already held for the current frame.
- R9: Software can write a slot or the enable register in any cycle, and reads back the written value combinationally on `cfg_rdata`.
- R10: With the registered output (default), `out_valid` rises exactly one clock after the accepted `rx_valid` cycle, and stays low when no character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received character is present this cycle |
| rx_char | input | CHAR_W | Received character; top bit is the address mark |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | CHAR_W-1 | Register write data |
| cfg_rdata | output | CHAR_W-1 | Read data of the selected register |
| out_valid | output | 1 | Forwarded character is present |
| out_char | output | CHAR_W | Forwarded character |

## Verification
The function pair that can coincide is a register write and the comparison of an address character. The bench places a slot write in the exact cycle that an address character equal to the new value arrives. It expects that address to miss against the old value, so the data that follows is dropped. A repeat of the same address one frame later must then hit. A second case rewrites a slot in the middle of an admitted frame and expects the following data to keep passing. Each forwarded character is judged against a queue filled by an independent model of the verdict.

// File: rtl/rx_amf_pkg.sv
package rx_amf_pkg;

   typedef enum logic {
      DECIDE_DROP = 1'b0,
      DECIDE_PASS = 1'b1
   } decide_e;

   // width of a select able to reach n slots plus the enable register
   function automatic int unsigned sel_bits(input int unsigned n);
      int unsigned w;
      w = $clog2(n + 1);
      if (w < 1) w = 1;
      return w;
   endfunction

endpackage

// File: rtl/rx_amf_cfg_regs.sv
module rx_amf_cfg_regs #(
   parameter int unsigned NUM_SLOTS = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_wr,
   input  logic [SEL_W-1:0]            cfg_sel,
   input  logic [ADDR_W-1:0]           cfg_wdata,
   output logic [ADDR_W-1:0]           cfg_rdata,
   output logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
   output logic [NUM_SLOTS-1:0]        slot_en
);

   localparam logic [SEL_W-1:0] CTRL_IDX = SEL_W'(NUM_SLOTS);

   logic [NUM_SLOTS-1:0] en_q;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         localparam logic [SEL_W-1:0] IDX = SEL_W'(s);
         logic [ADDR_W-1:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_q <= '0;
            else if (cfg_wr && (cfg_sel == IDX))
               addr_q <= cfg_wdata;
         end
         assign slot_addr[s*ADDR_W +: ADDR_W] = addr_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (cfg_wr && (cfg_sel == CTRL_IDX))
         en_q <= cfg_wdata[NUM_SLOTS-1:0];
   end

   assign slot_en = en_q;

   always_comb begin
      cfg_rdata = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (cfg_sel == SEL_W'(s))
            cfg_rdata = slot_addr[s*ADDR_W +: ADDR_W];
      end
      if (cfg_sel == CTRL_IDX)
         cfg_rdata[NUM_SLOTS-1:0] = en_q;
   end

endmodule

// File: rtl/rx_amf_addr_cmp.sv
module rx_amf_addr_cmp #(
   parameter int unsigned NUM_SLOTS = 2,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic [ADDR_W-1:0]           key,
   input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
   input  logic [NUM_SLOTS-1:0]        slot_en,
   output logic                        hit
);

   logic [NUM_SLOTS-1:0] hit_vec;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
         assign hit_vec[s] = slot_en[s] && (slot_addr[s*ADDR_W +: ADDR_W] == key);
      end
   endgenerate

   assign hit = |hit_vec;

endmodule

// File: rtl/rx_amf_gate.sv
module rx_amf_gate #(
   parameter int unsigned CHAR_W  = 9,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              filter_on,
   input  logic              slot_hit,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char
);
   import rx_amf_pkg::*;

   localparam int unsigned MARK_BIT = CHAR_W - 1;

   decide_e decide_q;
   logic    is_mark;
   logic    addr_seen;
   logic    fwd;

   assign is_mark   = in_char[MARK_BIT];
   assign addr_seen = in_valid && filter_on && is_mark;
   assign fwd       = in_valid && (!filter_on || (!is_mark && (decide_q == DECIDE_PASS)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         decide_q <= DECIDE_DROP;
      else if (addr_seen)
         decide_q <= slot_hit ? DECIDE_PASS : DECIDE_DROP;
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic              v_q;
         logic [CHAR_W-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= fwd;
               if (fwd) d_q <= in_char;
            end
         end
         assign out_valid = v_q;
         assign out_char  = d_q;
      end else begin : g_comb_out
         assign out_valid = fwd;
         assign out_char  = in_char;
      end
   endgenerate

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter  int unsigned CHAR_W    = 9,
   parameter  int unsigned NUM_SLOTS = 2,
   parameter  bit          OUT_REG   = 1'b1,
   localparam int unsigned ADDR_W    = CHAR_W - 1,
   localparam int unsigned SEL_W     = rx_amf_pkg::sel_bits(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              cfg_wr,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char
);

   generate
      if (CHAR_W < 2) begin : g_bad_width
         $error("rx_addr_filter: CHAR_W must be at least 2");
      end
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("rx_addr_filter: NUM_SLOTS must be at least 1");
      end
      if (ADDR_W < NUM_SLOTS) begin : g_bad_enable
         $error("rx_addr_filter: enable bits do not fit in the register data width");
      end
   endgenerate

   logic [NUM_SLOTS*ADDR_W-1:0] slot_addr;
   logic [NUM_SLOTS-1:0]        slot_en;
   logic                        slot_hit;
   logic                        filter_on;

   assign filter_on = |slot_en;

   rx_amf_cfg_regs #(
      .NUM_SLOTS (NUM_SLOTS),
      .ADDR_W    (ADDR_W),
      .SEL_W     (SEL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .slot_addr (slot_addr),
      .slot_en   (slot_en)
   );

   rx_amf_addr_cmp #(
      .NUM_SLOTS (NUM_SLOTS),
      .ADDR_W    (ADDR_W)
   ) u_cmp (
      .key       (rx_char[ADDR_W-1:0]),
      .slot_addr (slot_addr),
      .slot_en   (slot_en),
      .hit       (slot_hit)
   );

   rx_amf_gate #(
      .CHAR_W    (CHAR_W),
      .OUT_REG   (OUT_REG)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_valid),
      .in_char   (rx_char),
      .filter_on (filter_on),
      .slot_hit  (slot_hit),
      .out_valid (out_valid),
      .out_char  (out_char)
   );

endmodule

module rx_amf_chk #(
   parameter int unsigned CHAR_W    = 9,
   parameter int unsigned NUM_SLOTS = 2,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rx_valid,
   input logic [CHAR_W-1:0]    rx_char,
   input logic [NUM_SLOTS-1:0] slot_en,
   input logic                 out_valid,
   input logic [CHAR_W-1:0]    out_char
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   generate
      if (OUT_REG) begin : g_reg_props
         // R10
         out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (past_ok && $past(rx_valid)));

         // R2
         bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(rx_valid) && ($past(slot_en) == '0))
            |-> (out_valid && (out_char == $past(rx_char))));

         // R3
         mark_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(rx_valid) && $past(rx_char[CHAR_W-1]) && ($past(slot_en) != '0))
            |-> !out_valid);

         // R4
         data_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && out_valid) |-> (out_char == $past(rx_char)));
      end else begin : g_comb_props
         // R3
         mark_drop_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && rx_char[CHAR_W-1] && (slot_en != '0)) |-> !out_valid);

         // R4
         data_intact_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (rx_valid && (out_char == rx_char)));

         // R2
         bypass_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && (slot_en == '0)) |-> out_valid);

         // R10
         idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !rx_valid) |-> !out_valid);
      end
   endgenerate

endmodule

bind rx_addr_filter rx_amf_chk #(
   .CHAR_W    (CHAR_W),
   .NUM_SLOTS (NUM_SLOTS),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_char   (rx_char),
   .slot_en   (slot_en),
   .out_valid (out_valid),
   .out_char  (out_char)
);

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [8:0] rx_char = '0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       out_valid;
   logic [8:0] out_char;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   logic [7:0] m_addr [2];
   logic [1:0] m_en;
   bit         m_pass;

   always #5 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_char   (rx_char),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .out_valid (out_valid),
      .out_char  (out_char)
   );

   task automatic model_write(input logic [1:0] sel, input logic [7:0] data);
      if (sel == 2'd0) m_addr[0] = data;
      else if (sel == 2'd1) m_addr[1] = data;
      else if (sel == 2'd2) m_en = data[1:0];
   endtask

   function automatic logic [7:0] model_read(input logic [1:0] sel);
      if (sel == 2'd0) return m_addr[0];
      if (sel == 2'd1) return m_addr[1];
      if (sel == 2'd2) return {6'd0, m_en};
      return 8'd0;
   endfunction

   // driver: one character per call, optional register write in the same cycle
   task automatic drive(input logic [8:0] c, input string tag,
                        input bit w, input logic [1:0] sel, input logic [7:0] data);
      bit hit;
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_char   = c;
      cfg_wr    = w;
      cfg_sel   = sel;
      cfg_wdata = data;
      if (m_en == 2'b00) begin
         exp_q.push_back(c);
         tag_q.push_back(tag);
      end else if (c[8]) begin
         hit = (m_en[0] && (m_addr[0] == c[7:0])) || (m_en[1] && (m_addr[1] == c[7:0]));
         m_pass = hit;
      end else if (m_pass) begin
         exp_q.push_back(c);
         tag_q.push_back(tag);
      end
      if (w) model_write(sel, data);
   endtask

   task automatic send(input logic [8:0] c, input string tag);
      drive(c, tag, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic idle();
      @(negedge clk);
      rx_valid = 1'b0;
      cfg_wr   = 1'b0;
   endtask

   task automatic check_rd(input logic [1:0] sel, input string tag);
      logic [7:0] e;
      cfg_sel = sel;
      #1;
      e = model_read(sel);
      checks++;
      if (cfg_rdata !== e) begin
         fails++;
         $display("FAIL %s readback sel %0d: actual %h expected %h", tag, sel, cfg_rdata, e);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data, input string tag);
      @(negedge clk);
      rx_valid  = 1'b0;
      cfg_wr    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      model_write(sel, data);
      @(negedge clk);
      cfg_wr = 1'b0;
      check_rd(sel, tag);
   endtask

   task automatic drain(input string tag);
      idle();
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s pending outputs: actual %0d expected 0", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   // monitor: compares every forwarded character against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R3/R5/R6/R7 unexpected output: actual %h expected none", out_char);
            end else begin
               logic [8:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (out_char !== e) begin
                  fails++;
                  $display("FAIL %s forwarded char: actual %h expected %h", t, out_char, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      m_addr[0] = 8'h00;
      m_addr[1] = 8'h00;
      m_en      = 2'b00;
      m_pass    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      check_rd(2'd0, "R1");
      check_rd(2'd1, "R1");
      check_rd(2'd2, "R1");

      // R2 / R10: transparent mode, back-to-back characters including marked ones
      send(9'h041, "R2");
      send(9'h1AA, "R2");
      send(9'h17F, "R2");
      send(9'h000, "R10");
      drain("R2");

      // R9: program slots and enables
      wr_reg(2'd0, 8'h12, "R9");
      wr_reg(2'd1, 8'h34, "R9");
      wr_reg(2'd2, 8'h03, "R9");

      // R6: data before any address is dropped
      send(9'h055, "R6");
      drain("R6");

      // R3 / R4: match on slot 0, address itself not forwarded
      send(9'h112, "R3");
      send(9'h001, "R4");
      send(9'h002, "R4");
      drain("R4");

      // R5: no match, following data dropped
      send(9'h199, "R5");
      send(9'h003, "R5");
      drain("R5");

      // R4: match on slot 1
      send(9'h134, "R4");
      idle();
      send(9'h004, "R4");
      drain("R4");

      // R7: disable slot 1, its value no longer matches
      wr_reg(2'd2, 8'h01, "R7");
      send(9'h134, "R7");
      send(9'h005, "R7");
      drain("R7");

      // R8: write slot 0 in the same cycle as the address equal to the new value
      drive(9'h150, "R8", 1'b1, 2'd0, 8'h50);
      send(9'h006, "R8");
      drain("R8");
      check_rd(2'd0, "R9");
      send(9'h150, "R8");
      send(9'h007, "R8");
      drain("R8");

      // R8 / R9: rewrite slot 0 mid-frame, verdict kept
      wr_reg(2'd0, 8'h77, "R9");
      send(9'h008, "R8");
      drain("R8");

      // R2: all slots disabled again, everything forwarded
      wr_reg(2'd2, 8'h00, "R2");
      send(9'h1FF, "R2");
      send(9'h009, "R2");
      drain("R2");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule